// File: doc/BRIEF.md
# Inverter Bridge Protection Supervisor

This block sits between a PWM generator and the six gate-drive enables of a three-phase inverter bridge. It receives one active-low on/off command per switch and turns it into an active-high gate enable, unless a protection condition forbids it. Three kinds of protection are handled. The first is a short circuit seen on a digitized comparator at the low-side shunt. The second is under-voltage on the shared low-side drive supply. The third is under-voltage on any of the three floating high-side supplies.

A short circuit only counts once the comparator has stayed high for a blanking time, so that turn-on current spikes are ignored. A confirmed short circuit turns the three low-side switches off in the same cycle. It also starts one fixed-width active-low fault pulse, which models an open-drain line. A low-side under-voltage starts the same pulse and holds the low-side switches off. A high-side under-voltage removes only the upper switch of its own phase and leaves the fault line alone.

Any switch that was blocked comes back only on a fresh off-to-on command. A command that was already held on does not restart it. Each supply monitor has two comparator inputs, one below the trip level and one above the release level, which gives hysteresis. Each input passes through a two-flop synchronizer and a glitch filter.

Top module: `bridge_guard`

## Requirements
- R1: With no fault active, each gate enable is the inverse of its command: `gate_hi[i] = ~cmd_hi_n[i]` and `gate_lo[i] = ~cmd_lo_n[i]`. Bit i is phase i, and a low command means on.
- R2: An `oc_sense` high pulse shorter than `SC_BLANK` consecutive clock cycles has no effect on the gates or on `fault_n`.
- R3: Once `oc_sense` has been high on `SC_BLANK` consecutive rising edges, all three `gate_lo` bits are low right after that edge. `gate_hi` is not affected.
- R4: A new short circuit or low-side under-voltage drives `fault_n` low from the next rising edge. It stays low for exactly `FO_WIDTH` cycles.
- R5: A fault that appears while `fault_n` is already low neither restarts nor lengthens the pulse.
- R6: While `fault_n` is low, every low-side on command is ignored and `gate_lo` stays 0.
- R7: After a low-side block ends, a low-side switch whose command is still held on stays off. It turns on only after its command has been off for at least one rising edge and then on again.
- R8: Bit 0 of `uv_under`/`uv_clear` is the low-side supply. Once tripped by `uv_under`, it stays tripped while neither comparator is high and releases only through `uv_clear`. While it is tripped, `gate_lo` is 0 and one fault pulse is produced.
- R9: Bit i+1 of `uv_under`/`uv_clear` is the high-side supply of phase i. When it trips, only `gate_hi[i]` turns off. `fault_n` stays high and the other gates are unchanged.
- R10: After a high-side supply releases, `gate_hi[i]` stays off while its command is held on. It turns on only after an off-then-on command.
- R11: A supply comparator pulse shorter than `UV_FILT` cycles changes no supply state.
- R12: While `rst` is high, all gates are off and `fault_n` is high, and a running fault pulse is cleared. After reset, every supply starts in the tripped state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_hi_n | input | 3 | Upper-switch commands, low = on, bit i = phase i |
| cmd_lo_n | input | 3 | Lower-switch commands, low = on, bit i = phase i |
| oc_sense | input | 1 | Shunt over-current comparator, high = above trip level |
| uv_under | input | 4 | Supply below trip level; bit 0 low side, bit i+1 high side of phase i |
| uv_clear | input | 4 | Supply above release level; same bit order |
| gate_hi | output | 3 | Upper-switch gate enables, high = on |
| gate_lo | output | 3 | Lower-switch gate enables, high = on |
| fault_n | output | 1 | Active-low fault pulse (open-drain model) |

## Verification
Some rules are checked by assertions on every cycle. Low-side gates stay off whenever a short circuit is confirmed, the fault line is low or the low-side supply is tripped. A tripped high-side supply always holds its own upper gate off. A switch whose command was held on while blocked never turns on. A supply state only changes in the direction its comparator indicates. A fault edge is always followed by the fault line going low. Only the bench scenarios can show the timing and the outcomes. These are the exact blanking and pulse lengths, that a fault during a pulse leaves the pulse unchanged, that the hysteresis band holds between thresholds, that short glitches are rejected, that the fault line stays high on a high-side trip, and that reset ends a running pulse.

// File: rtl/bridge_guard_pkg.sv
package bridge_guard_pkg;

    localparam int unsigned PHASES    = 3;
    localparam int unsigned SUPPLIES  = PHASES + 1;
    localparam int unsigned LO_SUPPLY = 0;

    // One supply's pair of comparator levels
    typedef struct packed {
        logic under;
        logic clear;
    } uv_cmp_t;

    typedef enum logic {
        PULSE_IDLE = 1'b0,
        PULSE_ON   = 1'b1
    } pulse_state_e;

    // Width of a counter that must reach 'limit'
    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/bg_uv_monitor.sv
module bg_uv_monitor
    import bridge_guard_pkg::*;
#(
    parameter int unsigned FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic under_raw,
    input  logic clear_raw,
    output logic tripped
);
    localparam int unsigned     CW   = cnt_bits(FILT_LEN);
    localparam logic [CW-1:0]   LAST = CW'(FILT_LEN - 1);

    uv_cmp_t        meta_q;
    uv_cmp_t        sync_q;
    logic [CW-1:0]  run_q;
    logic           cond;

    // Two-flop synchronizer for both comparator levels
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= '{under: under_raw, clear: clear_raw};
            sync_q <= meta_q;
        end
    end

    // Tripped state looks for release, released state looks for trip
    assign cond = tripped ? sync_q.clear : sync_q.under;

    always_ff @(posedge clk) begin
        if (rst) begin
            tripped <= 1'b1;
            run_q   <= '0;
        end else if (cond) begin
            if (run_q == LAST) begin
                tripped <= ~tripped;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    AST_TRIP_NEEDS_UNDER: assert property (@(posedge clk) disable iff (rst)
        $rose(tripped) |-> $past(sync_q.under)); // R8
    AST_RELEASE_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(tripped) |-> $past(sync_q.clear)); // R8

endmodule

// File: rtl/bg_sc_filter.sv
module bg_sc_filter
    import bridge_guard_pkg::*;
#(
    parameter int unsigned BLANK = 90
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_raw,
    output logic sc_active
);
    localparam int unsigned    CW  = cnt_bits(BLANK);
    localparam logic [CW-1:0]  LIM = CW'(BLANK);

    logic [CW-1:0] hold_q;

    // Count consecutive high samples, saturating at the blanking length
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (oc_raw) begin
            if (hold_q != LIM) hold_q <= hold_q + 1'b1;
        end else begin
            hold_q <= '0;
        end
    end

    assign sc_active = (hold_q == LIM);

    AST_SC_NEEDS_SENSE: assert property (@(posedge clk) disable iff (rst)
        $rose(sc_active) |-> $past(oc_raw)); // R2

endmodule

// File: rtl/bg_fault_timer.sv
module bg_fault_timer
    import bridge_guard_pkg::*;
#(
    parameter int unsigned WIDTH = 90000
) (
    input  logic clk,
    input  logic rst,
    input  logic fault_req,
    output logic active
);
    localparam int unsigned    CW   = cnt_bits(WIDTH);
    localparam logic [CW-1:0]  LAST = CW'(WIDTH - 1);

    pulse_state_e   state_q;
    logic [CW-1:0]  age_q;
    logic           req_q;
    logic           req_edge;

    // Starts high so a fault already present at reset gives no pulse
    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b1;
        else     req_q <= fault_req;
    end

    assign req_edge = fault_req & ~req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PULSE_IDLE;
            age_q   <= '0;
        end else begin
            unique case (state_q)
                PULSE_IDLE: begin
                    if (req_edge) begin
                        state_q <= PULSE_ON;
                        age_q   <= '0;
                    end
                end
                PULSE_ON: begin
                    if (age_q == LAST) state_q <= PULSE_IDLE;
                    else               age_q   <= age_q + 1'b1;
                end
                default: state_q <= PULSE_IDLE;
            endcase
        end
    end

    assign active = (state_q == PULSE_ON);

    AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        active |-> (age_q <= LAST)); // R4

endmodule

// File: rtl/bg_leg.sv
module bg_leg (
    input  logic clk,
    input  logic rst,
    input  logic cmd_n,
    input  logic block,
    output logic gate
);
    logic cmd_on;
    logic lock_q;

    assign cmd_on = ~cmd_n;

    // Lock is set by any block and clears only while the command is off
    always_ff @(posedge clk) begin
        if (rst)          lock_q <= 1'b1;
        else if (block)   lock_q <= 1'b1;
        else if (!cmd_on) lock_q <= 1'b0;
    end

    assign gate = cmd_on & ~block & ~lock_q;

    AST_BLOCK_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        block |-> !gate); // R6
    AST_REARM_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_on && !gate) && cmd_on) |-> !gate); // R7

endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
    import bridge_guard_pkg::*;
#(
    parameter int unsigned SC_BLANK = 90,
    parameter int unsigned FO_WIDTH = 90000,
    parameter int unsigned UV_FILT  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PHASES-1:0]   cmd_hi_n,
    input  logic [PHASES-1:0]   cmd_lo_n,
    input  logic                oc_sense,
    input  logic [SUPPLIES-1:0] uv_under,
    input  logic [SUPPLIES-1:0] uv_clear,
    output logic [PHASES-1:0]   gate_hi,
    output logic [PHASES-1:0]   gate_lo,
    output logic                fault_n
);
    logic [SUPPLIES-1:0] uv_trip;
    logic                sc_active;
    logic                fault_active;
    logic                fault_req;
    logic                lo_block;

    for (genvar s = 0; s < SUPPLIES; s++) begin : g_supply
        bg_uv_monitor #(.FILT_LEN(UV_FILT)) u_mon (
            .clk       (clk),
            .rst       (rst),
            .under_raw (uv_under[s]),
            .clear_raw (uv_clear[s]),
            .tripped   (uv_trip[s])
        );
    end

    bg_sc_filter #(.BLANK(SC_BLANK)) u_sc (
        .clk       (clk),
        .rst       (rst),
        .oc_raw    (oc_sense),
        .sc_active (sc_active)
    );

    assign fault_req = sc_active | uv_trip[LO_SUPPLY];

    bg_fault_timer #(.WIDTH(FO_WIDTH)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .fault_req (fault_req),
        .active    (fault_active)
    );

    assign fault_n  = ~fault_active;
    assign lo_block = sc_active | fault_active | uv_trip[LO_SUPPLY];

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        bg_leg u_lo (
            .clk   (clk),
            .rst   (rst),
            .cmd_n (cmd_lo_n[p]),
            .block (lo_block),
            .gate  (gate_lo[p])
        );
        bg_leg u_hi (
            .clk   (clk),
            .rst   (rst),
            .cmd_n (cmd_hi_n[p]),
            .block (uv_trip[p+1]),
            .gate  (gate_hi[p])
        );

        AST_HI_UV_OFF: assert property (@(posedge clk) disable iff (rst)
            uv_trip[p+1] |-> !gate_hi[p]); // R9
    end

    AST_SC_LO_OFF: assert property (@(posedge clk) disable iff (rst)
        sc_active |-> (gate_lo == '0)); // R3
    AST_FAULT_LO_OFF: assert property (@(posedge clk) disable iff (rst)
        !fault_n |-> (gate_lo == '0)); // R6
    AST_LO_UV_OFF: assert property (@(posedge clk) disable iff (rst)
        uv_trip[LO_SUPPLY] |-> (gate_lo == '0)); // R8
    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (rst)
        ($rose(fault_req) && fault_n) |=> !fault_n); // R4

endmodule

// File: tb/bridge_guard_tb.sv
module bridge_guard_tb;
    localparam int unsigned SCB = 6;
    localparam int unsigned FOW = 30;
    localparam int unsigned UVF = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] cmd_hi_n, cmd_lo_n;
    logic       oc_sense;
    logic [3:0] uv_under, uv_clear;
    logic [2:0] gate_hi, gate_lo;
    logic       fault_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bridge_guard #(.SC_BLANK(SCB), .FO_WIDTH(FOW), .UV_FILT(UVF)) u_dut (
        .clk(clk), .rst(rst), .cmd_hi_n(cmd_hi_n), .cmd_lo_n(cmd_lo_n),
        .oc_sense(oc_sense), .uv_under(uv_under), .uv_clear(uv_clear),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
    );

    // {cmd_hi_n, cmd_lo_n, expected gate_hi, expected gate_lo}
    localparam logic [11:0] VEC [8] = '{
        12'b111_111_000_000, 12'b110_111_001_000,
        12'b101_011_010_100, 12'b011_101_100_010,
        12'b111_110_000_001, 12'b000_111_111_000,
        12'b111_000_000_111, 12'b010_101_101_010
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        int lowc;
        rst = 1'b1; cmd_hi_n = 3'b000; cmd_lo_n = 3'b000; oc_sense = 1'b0;
        uv_under = 4'b0000; uv_clear = 4'b1111;
        tick(3);
        // R12: reset state with commands on
        check("R12 gate_hi in reset", 8'(gate_hi), 8'h0);
        check("R12 gate_lo in reset", 8'(gate_lo), 8'h0);
        check("R12 fault_n in reset", 8'(fault_n), 8'h1);
        rst = 1'b0; cmd_hi_n = 3'b111; cmd_lo_n = 3'b111;
        tick(12);
        check("R12 no pulse after reset", 8'(fault_n), 8'h1);

        // R1: table walk
        for (int v = 0; v < 8; v++) begin
            cmd_hi_n = VEC[v][11:9];
            cmd_lo_n = VEC[v][8:6];
            tick(1);
            check("R1 gate_hi", 8'(gate_hi), 8'(VEC[v][5:3]));
            check("R1 gate_lo", 8'(gate_lo), 8'(VEC[v][2:0]));
        end
        cmd_hi_n = 3'b111; cmd_lo_n = 3'b111; tick(1);

        // R2: short over-current pulse ignored
        cmd_lo_n = 3'b000; tick(1);
        oc_sense = 1'b1; tick(SCB - 1); oc_sense = 1'b0;
        tick(4);
        check("R2 gate_lo after short pulse", 8'(gate_lo), 8'h7);
        check("R2 fault_n after short pulse", 8'(fault_n), 8'h1);

        // R3/R4/R5/R6: short-circuit trip
        cmd_hi_n = 3'b110; tick(1);
        oc_sense = 1'b1;
        tick(SCB - 1);
        check("R3 gate_lo before blank ends", 8'(gate_lo), 8'h7);
        tick(1);
        check("R3 gate_lo at trip", 8'(gate_lo), 8'h0);
        check("R3 gate_hi unaffected", 8'(gate_hi), 8'h1);
        check("R4 fault_n not yet low", 8'(fault_n), 8'h1);
        tick(1);
        oc_sense = 1'b0;
        lowc = 0;
        while (!fault_n && lowc < 200) begin
            lowc++;
            if (lowc == 5)  oc_sense = 1'b1;
            if (lowc == 15) oc_sense = 1'b0;
            if (lowc == 20) cmd_lo_n = 3'b111;
            if (lowc == 22) cmd_lo_n = 3'b000;
            if (lowc == 25) check("R6 on command ignored in pulse", 8'(gate_lo), 8'h0);
            tick(1);
        end
        check("R4 R5 pulse width", 8'(lowc), 8'(FOW));
        check("R7 held command stays off", 8'(gate_lo), 8'h0);
        cmd_lo_n = 3'b111; tick(1); cmd_lo_n = 3'b000; #1;
        check("R7 rearm after off-on", 8'(gate_lo), 8'h7);
        tick(1);

        // R8: low-side under-voltage with hysteresis
        uv_under[0] = 1'b1; uv_clear[0] = 1'b0;
        tick(8);
        check("R8 gate_lo off when tripped", 8'(gate_lo), 8'h0);
        check("R8 fault pulse on trip", 8'(fault_n), 8'h0);
        uv_under[0] = 1'b0;
        tick(40);
        check("R8 single pulse", 8'(fault_n), 8'h1);
        cmd_lo_n = 3'b111; tick(1); cmd_lo_n = 3'b000; #1;
        check("R8 held in band", 8'(gate_lo), 8'h0);
        uv_clear[0] = 1'b1;
        tick(8);
        check("R8 R7 locked after release", 8'(gate_lo), 8'h0);
        cmd_lo_n = 3'b111; tick(1); cmd_lo_n = 3'b000; #1;
        check("R8 resumes after release", 8'(gate_lo), 8'h7);
        tick(1);

        // R11: glitch on a supply comparator
        uv_under[0] = 1'b1; tick(UVF - 1); uv_under[0] = 1'b0;
        tick(10);
        check("R11 gate_lo after glitch", 8'(gate_lo), 8'h7);
        check("R11 fault_n after glitch", 8'(fault_n), 8'h1);

        // R9/R10: high-side under-voltage on phase 1
        cmd_hi_n = 3'b000; tick(1);
        check("R9 all upper on", 8'(gate_hi), 8'h7);
        uv_under[2] = 1'b1; uv_clear[2] = 1'b0;
        tick(8);
        check("R9 only phase 1 upper off", 8'(gate_hi), 8'h5);
        check("R9 fault_n stays high", 8'(fault_n), 8'h1);
        check("R9 lower gates unchanged", 8'(gate_lo), 8'h7);
        uv_under[2] = 1'b0; uv_clear[2] = 1'b1;
        tick(8);
        check("R10 held command stays off", 8'(gate_hi), 8'h5);
        cmd_hi_n[1] = 1'b1; tick(1); cmd_hi_n[1] = 1'b0; #1;
        check("R10 resumes on new command", 8'(gate_hi), 8'h7);
        tick(1);

        // R12: reset clears a running pulse
        oc_sense = 1'b1; tick(SCB + 4);
        check("R12 pulse running", 8'(fault_n), 8'h0);
        rst = 1'b1; tick(2);
        check("R12 pulse cleared by reset", 8'(fault_n), 8'h1);
        check("R12 gates off in reset", 8'({gate_hi, gate_lo}), 8'h0);
        oc_sense = 1'b0;
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

endmodule